// File: doc/BRIEF.md
# Fuzzy Yaw-Rate Controller Core

This core turns a yaw-rate error and its change into a desired steering-angle command. Both inputs are 8-bit offset-coded samples. Code 0 is the most negative value, code 255 the most positive value, and codes from 128 upward mean a positive quantity. For the yaw-rate scale, code 0 stands for -100 °/s and code 255 for +100 °/s. Each input is graded against seven triangular sets, ordered from negative big to positive big. Every one of the 49 pairs of sets selects one output set, and each pair fires with the smaller of its two grades. The result is the weighted average of the singleton centres of the selected output sets, mapped linearly onto a signed angle.

The work is done step by step rather than in a parallel array. First the 49 rules are visited one per clock while the numerator and denominator are accumulated. Then a restoring divider computes the quotient one bit per clock. Operands arrive on a valid/ready input stream, and the command leaves on a valid/ready output stream. Back-pressure rules:
- Only one operation is in flight at a time.
- `in_ready` is low from acceptance until the result has been taken.
- A held result does not change until `out_ready` is seen high.

The `done` status pin pulses once when a fresh quotient becomes visible.

Top module: `fyc_core`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while the core is idle. `in_valid` and operand values presented while the core is busy have no effect on the result.
- R3: Set k (k = 0..6, NB..PB) has its peak at c_k = floor((255·k + 3)/6), giving 0, 43, 85, 128, 170, 213 and 255. Grades follow the segment that holds x:
  - For x in [c_s, c_(s+1)), set s+1 gets g = min(255, 6·(x − c_s)) and set s gets 255 − g.
  - At x = 255 only set 6 has a grade, equal to 255.
  - Every other set has grade 0.
- R4: The rule for error set i and change set j selects output set clamp(i + j − 3, 0, 6). It fires with weight min(grade_e[i], grade_d[j]).
- R5: Output set m has centre m·STEP, with STEP = 2600. The command is floor(Σw·centre / Σw) − 3·STEP in 16-bit two's complement. It therefore always lies within ±7800. If Σw is 0, the command is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_angle` stay unchanged. After a cycle with both high, `out_valid` is 0 and `in_ready` is 1.
- R7: `done` is 1 for exactly the first cycle in which a new result is valid, and 0 at all other times.
- R8: The end codes give the end commands:
  - Both inputs at 255 give +7800.
  - Both inputs at 0 give −7800.
  - Both inputs at 128, or one input at 0 and the other at 255, give 0.
- R9: When both inputs sit exactly on set peaks, the command equals the centre of that single rule's output set. For example, codes 170 and 213 give +7800, and codes 43 and 170 give −2600.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Core idle and able to take operands |
| in_err | input | 8 | Yaw-rate error, offset coded |
| in_derr | input | 8 | Change of error, offset coded |
| out_valid | output | 1 | Command available |
| out_ready | input | 1 | Consumer takes the command |
| out_angle | output | 16 | Desired steering angle, two's complement |
| done | output | 1 | One-cycle pulse on a fresh result |

## Verification
Two situations are the hardest to reach from the ports.

The first is a grade saturating or a segment switching exactly at a peak code. It only shows up for a few input codes, such as one below a peak, the peak itself and code 255. The stimulus therefore mixes uniformly random operands with codes drawn from each peak plus or minus one.

The second is an operand change arriving while a computation is underway. To reach it, the bench keeps `in_valid` high with altered data through several busy cycles. It also holds `out_ready` low for random spans, so that stability under back-pressure and the single `done` pulse are both exercised.

// File: rtl/fyc_pkg.sv
package fyc_pkg;

  // Seven linguistic sets, index 0 = most negative, 6 = most positive
  localparam int NSET = 7;
  localparam int NSEG = NSET - 1;
  localparam int MID  = NSET / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RULES,
    ST_DIV,
    ST_HOLD
  } fyc_state_e;

  // Peak position of set k on an input scale running 0..in_max
  function automatic int set_center(input int k, input int in_max);
    return (k * in_max + NSEG / 2) / NSEG;
  endfunction

  // Output set picked by the rule for error set ie and change set id
  function automatic int rule_out(input int ie, input int id);
    int s;
    s = ie + id - MID;
    if (s < 0)    s = 0;
    if (s > NSEG) s = NSEG;
    return s;
  endfunction

endpackage

// File: rtl/fyc_fuzzifier.sv
module fyc_fuzzifier
  import fyc_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int MU_W = 8
) (
  input  logic [IN_W-1:0]           x,
  output logic [NSET-1:0][MU_W-1:0] mu
);

  localparam int IN_MAX = (1 << IN_W) - 1;
  localparam int MU_MAX = (1 << MU_W) - 1;
  localparam int SLOPE  = (MU_MAX * NSEG + IN_MAX - 1) / IN_MAX;
  localparam int PW     = IN_W + $clog2(SLOPE + 1);

  function automatic logic [MU_W-1:0] sat(input logic [PW-1:0] v);
    return (v > PW'(MU_MAX)) ? MU_W'(MU_MAX) : v[MU_W-1:0];
  endfunction

  for (genvar k = 0; k < NSET; k++) begin : g_set
    localparam int C_K = set_center(k, IN_MAX);

    if (k == 0) begin : g_first
      localparam int C_HI = set_center(k + 1, IN_MAX);
      logic [PW-1:0] dn;
      always_comb begin
        dn = PW'(x) * PW'(SLOPE);
        mu[k] = (x < IN_W'(C_HI)) ? MU_W'(MU_MAX) - sat(dn) : '0;
      end
    end else if (k == NSEG) begin : g_last
      localparam int C_LO = set_center(k - 1, IN_MAX);
      logic [PW-1:0] up;
      always_comb begin
        up = PW'(x - IN_W'(C_LO)) * PW'(SLOPE);
        if (x == IN_W'(IN_MAX))
          mu[k] = MU_W'(MU_MAX);
        else if (x >= IN_W'(C_LO))
          mu[k] = sat(up);
        else
          mu[k] = '0;
      end
    end else begin : g_mid
      localparam int C_LO = set_center(k - 1, IN_MAX);
      localparam int C_HI = set_center(k + 1, IN_MAX);
      logic [PW-1:0] up, dn;
      always_comb begin
        up = PW'(x - IN_W'(C_LO)) * PW'(SLOPE);
        dn = PW'(x - IN_W'(C_K)) * PW'(SLOPE);
        if (x >= IN_W'(C_K) && x < IN_W'(C_HI))
          mu[k] = MU_W'(MU_MAX) - sat(dn);
        else if (x >= IN_W'(C_LO) && x < IN_W'(C_K))
          mu[k] = sat(up);
        else
          mu[k] = '0;
      end
    end
  end

endmodule

// File: rtl/fyc_rule_engine.sv
module fyc_rule_engine
  import fyc_pkg::*;
#(
  parameter int MU_W  = 8,
  parameter int STEP  = 2600,
  parameter int DEN_W = 14,
  parameter int NUM_W = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NSET-1:0][MU_W-1:0] mu_e,
  input  logic [NSET-1:0][MU_W-1:0] mu_d,
  output logic                      done,
  output logic [NUM_W-1:0]          num,
  output logic [DEN_W-1:0]          den
);

  localparam int IDX_W = $clog2(NSET);

  logic [IDX_W-1:0] ie, id;
  logic             active;
  logic [MU_W-1:0]  ge, gd, w;
  logic [NUM_W-1:0] center, prod;
  logic             last;
  int               m;

  always_comb begin
    ge     = mu_e[ie];
    gd     = mu_d[id];
    w      = (ge < gd) ? ge : gd;
    m      = rule_out(int'(ie), int'(id));
    center = NUM_W'(m) * NUM_W'(STEP);
    prod   = NUM_W'(w) * center;
    last   = (ie == IDX_W'(NSEG)) && (id == IDX_W'(NSEG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie     <= '0;
      id     <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      num    <= '0;
      den    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        ie     <= '0;
        id     <= '0;
        active <= 1'b1;
        num    <= '0;
        den    <= '0;
      end else if (active) begin
        if (w != '0) begin
          num <= num + prod;
          den <= den + DEN_W'(w);
        end
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else if (id == IDX_W'(NSEG)) begin
          id <= '0;
          ie <= ie + 1'b1;
        end else begin
          id <= id + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fyc_divider.sv
module fyc_divider #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 14,
  parameter int QW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [QW-1:0]    quot
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] rem, dv;
  logic [DEN_W:0]   trial, diff;
  logic [CNT_W-1:0] cnt;
  logic             busy, fits;

  always_comb begin
    trial = {rem, q[NUM_W-1]};
    diff  = trial - {1'b0, dv};
    fits  = trial >= {1'b0, dv};
  end

  assign quot = q[QW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      rem  <= '0;
      dv   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q    <= num;
        dv   <= den;
        rem  <= '0;
        cnt  <= CNT_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        q   <= {q[NUM_W-2:0], fits};
        rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fyc_core.sv
module fyc_core
  import fyc_pkg::*;
#(
  parameter int IN_W    = 8,
  parameter int MU_W    = 8,
  parameter int ANGLE_W = 16,
  parameter int STEP    = 2600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_W-1:0]    in_err,
  input  logic [IN_W-1:0]    in_derr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ANGLE_W-1:0] out_angle,
  output logic               done
);

  localparam int DEN_W  = MU_W + $clog2(NSET * NSET);
  localparam int NUM_W  = DEN_W + ANGLE_W;
  localparam int OFFSET = MID * STEP;

  fyc_state_e               state;
  logic [IN_W-1:0]          err_q, derr_q;
  logic [ANGLE_W-1:0]       angle_q;
  logic                     done_q;
  logic                     accept;
  logic [NSET-1:0][MU_W-1:0] mu_e, mu_d;
  logic                     rule_done, div_done;
  logic [NUM_W-1:0]         num;
  logic [DEN_W-1:0]         den;
  logic [ANGLE_W-1:0]       quot;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign out_angle = angle_q;
  assign done      = done_q;
  assign accept    = in_valid && in_ready;

  fyc_fuzzifier #(.IN_W(IN_W), .MU_W(MU_W)) fuzz_e_i (
    .x  (err_q),
    .mu (mu_e)
  );

  fyc_fuzzifier #(.IN_W(IN_W), .MU_W(MU_W)) fuzz_d_i (
    .x  (derr_q),
    .mu (mu_d)
  );

  fyc_rule_engine #(
    .MU_W(MU_W), .STEP(STEP), .DEN_W(DEN_W), .NUM_W(NUM_W)
  ) rules_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .mu_e  (mu_e),
    .mu_d  (mu_d),
    .done  (rule_done),
    .num   (num),
    .den   (den)
  );

  fyc_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QW(ANGLE_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rule_done),
    .num   (num),
    .den   (den),
    .done  (div_done),
    .quot  (quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_q   <= '0;
      derr_q  <= '0;
      angle_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          err_q  <= in_err;
          derr_q <= in_derr;
          state  <= ST_RULES;
        end
        ST_RULES: if (rule_done) state <= ST_DIV;
        ST_DIV: if (div_done) begin
          angle_q <= (den == '0) ? '0 : quot - ANGLE_W'(OFFSET);
          done_q  <= 1'b1;
          state   <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fyc_core_chk.sv
module fyc_core_chk #(
  parameter int ANGLE_W = 16,
  parameter int LIMIT   = 7800
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ANGLE_W-1:0] out_angle,
  input logic               done
);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_angle)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_angle_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_angle) <= LIMIT && $signed(out_angle) >= -LIMIT));

endmodule

bind fyc_core fyc_core_chk #(.ANGLE_W(ANGLE_W), .LIMIT(3 * STEP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_angle (out_angle),
  .done      (done)
);

// File: tb/fyc_core_tb.sv
module fyc_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 2600;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_err = '0;
  logic [7:0]  in_derr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_angle;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fyc_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_err    (in_err),
    .in_derr   (in_derr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_angle (out_angle),
    .done      (done)
  );

  function automatic int peak(input int k);
    return (k * 255 + 3) / 6;
  endfunction

  function automatic int lim(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  // R3 grade of input code x in set k
  function automatic int grade(input int x, input int k);
    if (k == 6) begin
      if (x == 255) return 255;
      if (x >= peak(5)) return lim((x - peak(5)) * 6);
      return 0;
    end
    if (x >= peak(k) && x < peak(k + 1)) return 255 - lim((x - peak(k)) * 6);
    if (k > 0 && x >= peak(k - 1) && x < peak(k)) return lim((x - peak(k - 1)) * 6);
    return 0;
  endfunction

  // R4/R5 expected command
  function automatic int model(input int e, input int d);
    longint num = 0;
    longint den = 0;
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        int w;
        int m;
        w = (grade(e, i) < grade(d, j)) ? grade(e, i) : grade(d, j);
        m = i + j - 3;
        if (m < 0) m = 0;
        if (m > 6) m = 6;
        num += longint'(w) * m * STEP;
        den += w;
      end
    end
    if (den == 0) return 0;
    return int'(num / den) - 3 * STEP;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ang();
    return int'($signed(out_angle));
  endfunction

  task automatic run_vec(input string tag, input int e, input int d, input int hold, input bit junk);
    int exp;
    exp = model(e, d);
    @(negedge clk);
    chk("R2 ready when idle", int'(in_ready), 1);
    in_valid = 1'b1;
    in_err   = 8'(e);
    in_derr  = 8'(d);
    @(negedge clk);
    if (junk) begin
      in_err  = ~8'(e);
      in_derr = 8'(d + 37);
      repeat (3) begin
        chk("R2 not ready while busy", int'(in_ready), 0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk("R7 done on first valid cycle", int'(done), 1);
    chk(tag, ang(), exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R6 valid held", int'(out_valid), 1);
      chk("R6 angle held", ang(), exp);
      chk("R7 done only once", int'(done), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 valid drops after take", int'(out_valid), 0);
    chk("R6 idle after take", int'(in_ready), 1);
  endtask

  function automatic int pick();
    if ($urandom % 2 == 0) return int'($urandom % 256);
    begin
      int v;
      v = peak(int'($urandom % 7)) + int'($urandom % 3) - 1;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      return v;
    end
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == WD_LIMIT) begin
        n_fail++;
        $display("FAIL R6 watchdog: actual no completion, expected completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready idle", int'(in_ready), 1);

    run_vec("R8 both top", 255, 255, 0, 1'b0);
    run_vec("R8 both bottom", 0, 0, 1, 1'b0);
    run_vec("R8 both middle", 128, 128, 0, 1'b1);
    run_vec("R8 top/bottom", 255, 0, 2, 1'b0);
    run_vec("R8 bottom/top", 0, 255, 0, 1'b0);
    run_vec("R9 peaks 170/213", 170, 213, 0, 1'b0);
    run_vec("R9 peaks 43/170", 43, 170, 1, 1'b1);
    run_vec("R4 clamp high 213/213", 213, 213, 0, 1'b0);
    run_vec("R4 clamp low 43/0", 43, 0, 0, 1'b0);
    run_vec("R5 between peaks 100/128", 100, 128, 3, 1'b0);
    run_vec("R3 one below peak 42/212", 42, 212, 0, 1'b1);
    run_vec("R3 near top 254/1", 254, 1, 0, 1'b0);

    for (int n = 0; n < 200; n++) begin
      int e, d;
      e = pick();
      d = pick();
      run_vec("R3 random pair", e, d, int'($urandom % 4), bit'($urandom % 2));
    end

    finish_run();
  end

endmodule